// File: doc/BRIEF.md
# Zero-Preserving Ternary Link Codec

This block joins a sender and a receiver across a delay-insensitive parallel link. The link has one three-level line per data bit. Each line is modelled here as a 2-bit code that stands for low, high or intermediate. The intermediate level is the spacer, which marks the gap between two words.

The sender accepts a word through a request/ready handshake and drives it onto the lines. It waits for acknowledge, then returns the link to spacer with as few line changes as it can. Only lines that carried a 1 move to intermediate. Lines that carried a 0 stay low. The one exception is an all-zero word: a zero detector catches it and sends every line to intermediate, because otherwise the receiver could never see the word end.

The receiver watches the lines and classifies the word:
- It is valid when no line is intermediate or illegal.
- On the first valid cycle the receiver latches the word, pulses a strobe and raises acknowledge.
- It drops acknowledge as soon as any single line shows intermediate.

For each word, a counter reports how many line-level changes the word caused. The sender's bus and the receiver's input are separate ports, so the link between them can be routed, delayed or disturbed outside the block.

Top module: `tern_link_codec`

## Requirements
- R1: After reset every transmit line reads intermediate (2'b10), acknowledge and the strobe are low, ready is high and the transition report is zero.
- R2: A word accepted with request and ready high appears on the transmit lines one cycle later. Line i occupies bits [2i+1:2i] and reads 2'b01 for a 1 and 2'b00 for a 0.
- R3: One cycle after the sender sees acknowledge, every line whose bit was 1 reads intermediate (2'b10).
- R4: For a word with at least one 1, every line whose bit was 0 keeps 2'b00 through the spacer phase.
- R5: For the all-zero word, every line reads intermediate during the spacer phase.
- R6: The receiver accepts a word only when no line is 2'b10 or 2'b11. On that cycle it latches the data, pulses the strobe for exactly one cycle and raises acknowledge.
- R7: Acknowledge stays high while every line is valid and falls on the cycle after any single line reads intermediate.
- R8: Ready is low from the accepting cycle until the sender has seen acknowledge fall after the spacer. No new word reaches the lines before then.
- R9: A line reading the illegal code 2'b11 raises the error output on the next cycle. Such a word is never accepted. The error output clears once the code is gone.
- R10: When a word's spacer phase ends, the transition report equals the count of line changes that word caused. This is its data-phase changes plus its spacer-phase changes, and it never exceeds twice the word width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_data | input | W | Word to send |
| in_req | input | 1 | Word offered |
| in_rdy | output | 1 | Sender can take a word |
| tx_lines | output | 2W | Sender line codes, 2 bits per line |
| tx_ack | input | 1 | Acknowledge as seen by the sender |
| rx_lines | input | 2W | Line codes as seen by the receiver |
| rx_ack | output | 1 | Receiver acknowledge |
| out_data | output | W | Latched word |
| out_valid | output | 1 | One-cycle strobe on a new word |
| line_err | output | 1 | An illegal line code was seen last cycle |
| word_trans | output | clog2(2W+1) | Line changes caused by the last finished word |

## Verification
The hardest situation to reach is one where the number of changes depends on the previous word. Whether a line moves when a new word starts depends on whether the previous word left it low or at intermediate. Sending each word once therefore misses most cases. The bench sends every ordered pair of 4-bit words, so each line sees every combination of previous and next level, including all-zero words before and after non-zero ones. The illegal code cannot come from the sender at all, so the bench overrides the receiver's line input with a pattern that contains one illegal line.

// File: rtl/tlc_pkg.sv
package tlc_pkg;
    typedef logic [1:0] lvl_t;

    localparam lvl_t LV_LO  = 2'b00;
    localparam lvl_t LV_HI  = 2'b01;
    localparam lvl_t LV_MID = 2'b10;
    localparam lvl_t LV_BAD = 2'b11;

    typedef enum logic [1:0] {
        TX_IDLE  = 2'd0,
        TX_DATA  = 2'd1,
        TX_SPACE = 2'd2
    } tx_st_e;

    typedef enum logic {
        RX_WAIT = 1'b0,
        RX_HELD = 1'b1
    } rx_st_e;

    function automatic lvl_t enc_bit(input logic b);
        return b ? LV_HI : LV_LO;
    endfunction
endpackage

// File: rtl/tlc_lane_dec.sv
module tlc_lane_dec
    import tlc_pkg::*;
(
    input  lvl_t lvl,
    output logic is_mid,
    output logic is_bad,
    output logic bit_val
);
    always_comb begin
        is_mid  = (lvl == LV_MID);
        is_bad  = (lvl == LV_BAD);
        bit_val = (lvl == LV_HI);
    end
endmodule

// File: rtl/tlc_sender.sv
module tlc_sender
    import tlc_pkg::*;
#(
    parameter int W = 4,
    localparam int LW = 2 * W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  in_data,
    input  logic          in_req,
    output logic          in_rdy,
    input  logic          ack,
    output logic [LW-1:0] lines,
    output logic [LW-1:0] lines_nxt,
    output logic          word_end
);
    typedef struct packed {
        tx_st_e        st;
        logic [W-1:0]  word;
        logic [LW-1:0] lines;
    } tx_s;

    tx_s s_d, s_q;
    logic word_zero;

    // zero detector for the held word
    assign word_zero = ~|s_q.word;

    always_comb begin
        s_d      = s_q;
        word_end = 1'b0;
        unique case (s_q.st)
            TX_IDLE: begin
                if (in_req && !ack) begin
                    s_d.word = in_data;
                    for (int i = 0; i < W; i++) begin
                        s_d.lines[2*i +: 2] = enc_bit(in_data[i]);
                    end
                    s_d.st = TX_DATA;
                end
            end
            TX_DATA: begin
                if (ack) begin
                    for (int i = 0; i < W; i++) begin
                        if (word_zero || s_q.word[i]) begin
                            s_d.lines[2*i +: 2] = LV_MID;
                        end
                    end
                    s_d.st = TX_SPACE;
                end
            end
            TX_SPACE: begin
                if (!ack) begin
                    s_d.st   = TX_IDLE;
                    word_end = 1'b1;
                end
            end
            default: s_d.st = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.st    <= TX_IDLE;
            s_q.word  <= '0;
            s_q.lines <= {W{LV_MID}};
        end else begin
            s_q <= s_d;
        end
    end

    assign in_rdy    = (s_q.st == TX_IDLE) && !ack;
    assign lines     = s_q.lines;
    assign lines_nxt = s_d.lines;

    // R2: a driven word holds still while waiting for acknowledge
    p_data_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == TX_DATA && $past(s_q.st) == TX_DATA) |-> $stable(s_q.lines));

    // R8: a new word only follows a low acknowledge
    p_next_wait_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == TX_DATA && $past(s_q.st) == TX_IDLE) |-> !$past(ack));

    // R5: all-zero word puts every line at the spacer
    p_allzero_mid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == TX_SPACE && word_zero) |-> (s_q.lines == {W{LV_MID}}));

    for (genvar g = 0; g < W; g++) begin : g_lane_chk
        // R3: lines that carried a one move to intermediate
        p_one_mid_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (s_q.st == TX_SPACE && s_q.word[g]) |-> (s_q.lines[2*g +: 2] == LV_MID));
        // R4: lines that carried a zero do not move on entering the spacer
        p_zero_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (s_q.st == TX_SPACE && $past(s_q.st) == TX_DATA && !word_zero && !s_q.word[g])
            |-> ($stable(s_q.lines[2*g +: 2]) && s_q.lines[2*g +: 2] == LV_LO));
    end
endmodule

// File: rtl/tlc_trans_count.sv
module tlc_trans_count
    import tlc_pkg::*;
#(
    parameter int W = 4,
    localparam int LW = 2 * W,
    localparam int CW = $clog2(2 * W + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [LW-1:0] cur,
    input  logic [LW-1:0] nxt,
    input  logic          word_end,
    output logic [CW-1:0] word_trans
);
    typedef struct packed {
        logic [CW-1:0] acc;
        logic [CW-1:0] rep;
    } cnt_s;

    cnt_s s_d, s_q;
    logic [CW-1:0] diff;

    always_comb begin
        diff = '0;
        for (int i = 0; i < W; i++) begin
            if (cur[2*i +: 2] != nxt[2*i +: 2]) diff = diff + CW'(1);
        end
        s_d = s_q;
        if (word_end) begin
            s_d.rep = s_q.acc + diff;
            s_d.acc = '0;
        end else begin
            s_d.acc = s_q.acc + diff;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign word_trans = s_q.rep;

    // R10: no word changes more lines than a full return-to-spacer cycle
    p_trans_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        word_end |-> ((32'(s_q.acc) + 32'(diff)) <= 2 * W));
endmodule

// File: rtl/tlc_receiver.sv
module tlc_receiver
    import tlc_pkg::*;
#(
    parameter int W = 4,
    localparam int LW = 2 * W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [LW-1:0] lines,
    output logic          ack,
    output logic [W-1:0]  data,
    output logic          valid,
    output logic          err
);
    typedef struct packed {
        rx_st_e       st;
        logic         ack;
        logic [W-1:0] data;
        logic         vld;
        logic         err;
    } rx_s;

    rx_s s_d, s_q;
    logic [W-1:0] mid_v, bad_v, bit_v;
    logic any_mid, any_bad, all_valid;

    for (genvar g = 0; g < W; g++) begin : g_lane
        tlc_lane_dec u_dec (
            .lvl    (lines[2*g +: 2]),
            .is_mid (mid_v[g]),
            .is_bad (bad_v[g]),
            .bit_val(bit_v[g])
        );
    end

    assign any_mid   = |mid_v;
    assign any_bad   = |bad_v;
    assign all_valid = !any_mid && !any_bad;

    always_comb begin
        s_d     = s_q;
        s_d.vld = 1'b0;
        s_d.err = any_bad;
        unique case (s_q.st)
            RX_WAIT: begin
                if (all_valid) begin
                    s_d.data = bit_v;
                    s_d.vld  = 1'b1;
                    s_d.ack  = 1'b1;
                    s_d.st   = RX_HELD;
                end
            end
            RX_HELD: begin
                if (any_mid) begin
                    s_d.ack = 1'b0;
                    s_d.st  = RX_WAIT;
                end
            end
            default: s_d.st = RX_WAIT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.st   <= RX_WAIT;
            s_q.ack  <= 1'b0;
            s_q.data <= '0;
            s_q.vld  <= 1'b0;
            s_q.err  <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ack   = s_q.ack;
    assign data  = s_q.data;
    assign valid = s_q.vld;
    assign err   = s_q.err;

    // R6: acknowledge only rises after a fully valid word
    p_ack_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.ack) |-> $past(all_valid));

    // R6: the strobe only comes with acknowledge
    p_vld_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.vld |-> s_q.ack);

    // R7: acknowledge only falls after an intermediate line
    p_ack_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(s_q.ack) |-> $past(any_mid));

    // R9: an illegal code never lets a word in
    p_bad_noacc_r9: assert property (@(posedge clk) disable iff (!rst_n)
        any_bad |=> !$rose(s_q.ack));
endmodule

// File: rtl/tern_link_codec.sv
module tern_link_codec
    import tlc_pkg::*;
#(
    parameter int W = 4,
    localparam int LW = 2 * W,
    localparam int CW = $clog2(2 * W + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  in_data,
    input  logic          in_req,
    output logic          in_rdy,
    output logic [LW-1:0] tx_lines,
    input  logic          tx_ack,
    input  logic [LW-1:0] rx_lines,
    output logic          rx_ack,
    output logic [W-1:0]  out_data,
    output logic          out_valid,
    output logic          line_err,
    output logic [CW-1:0] word_trans
);
    logic [LW-1:0] lines_nxt;
    logic          word_end;

    tlc_sender #(.W(W)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_data  (in_data),
        .in_req   (in_req),
        .in_rdy   (in_rdy),
        .ack      (tx_ack),
        .lines    (tx_lines),
        .lines_nxt(lines_nxt),
        .word_end (word_end)
    );

    tlc_trans_count #(.W(W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .cur       (tx_lines),
        .nxt       (lines_nxt),
        .word_end  (word_end),
        .word_trans(word_trans)
    );

    tlc_receiver #(.W(W)) u_rx (
        .clk  (clk),
        .rst_n(rst_n),
        .lines(rx_lines),
        .ack  (rx_ack),
        .data (out_data),
        .valid(out_valid),
        .err  (line_err)
    );
endmodule

// File: tb/tern_link_codec_bench.sv
module tern_link_codec_bench;
    localparam int W     = 4;
    localparam int LW    = 2 * W;
    localparam int CW    = $clog2(2 * W + 1);
    localparam int T_CLK = 10;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [W-1:0]  in_data;
    logic          in_req;
    logic          in_rdy;
    logic [LW-1:0] tx_lines;
    logic          tx_ack;
    logic [LW-1:0] rx_lines;
    logic          rx_ack;
    logic [W-1:0]  out_data;
    logic          out_valid;
    logic          line_err;
    logic [CW-1:0] word_trans;
    logic          force_en;
    logic [LW-1:0] force_val;

    int checks = 0;
    int errors = 0;
    int total_tr = 0;
    int words = 0;
    logic [LW-1:0] lvl_m;
    bit done = 0;

    always #(T_CLK / 2) clk = ~clk;

    assign rx_lines = force_en ? force_val : tx_lines;
    assign tx_ack   = rx_ack;

    tern_link_codec #(.W(W)) u_tern_link_codec (
        .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_req(in_req),
        .in_rdy(in_rdy), .tx_lines(tx_lines), .tx_ack(tx_ack),
        .rx_lines(rx_lines), .rx_ack(rx_ack), .out_data(out_data),
        .out_valid(out_valid), .line_err(line_err), .word_trans(word_trans)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic send(input logic [W-1:0] w);
        logic [LW-1:0] dat_e, spc_e;
        int tr;
        tr = 0;
        for (int i = 0; i < W; i++) begin
            dat_e[2*i +: 2] = w[i] ? 2'b01 : 2'b00;
            spc_e[2*i +: 2] = (w == '0 || w[i]) ? 2'b10 : 2'b00;
            if (lvl_m[2*i +: 2] != dat_e[2*i +: 2]) tr++;
            if (dat_e[2*i +: 2] != spc_e[2*i +: 2]) tr++;
        end
        while (!in_rdy) @(negedge clk);
        in_data = w;
        in_req  = 1'b1;
        @(negedge clk);
        in_req  = 1'b0;
        chk(tx_lines == dat_e, "R2 data encoding", tx_lines, dat_e);
        chk(!in_rdy, "R8 ready low after accept", in_rdy, 0);
        @(negedge clk);
        chk(out_valid && out_data == w, "R6 latched word", {out_valid, out_data}, {1'b1, w});
        chk(rx_ack, "R6 acknowledge raised", rx_ack, 1);
        @(negedge clk);
        if (w == '0) chk(tx_lines == spc_e, "R5 all-zero spacer", tx_lines, spc_e);
        else         chk(tx_lines == spc_e, "R3 R4 partial spacer", tx_lines, spc_e);
        chk(rx_ack, "R7 ack held until spacer seen", rx_ack, 1);
        chk(!out_valid, "R6 strobe one cycle", out_valid, 0);
        @(negedge clk);
        chk(!rx_ack, "R7 ack dropped on spacer", rx_ack, 0);
        chk(!in_rdy, "R8 ready low until ack seen low", in_rdy, 0);
        @(negedge clk);
        chk(in_rdy, "R8 ready back", in_rdy, 1);
        chk(int'(word_trans) == tr, "R10 transition report", word_trans, tr);
        chk(int'(word_trans) <= 2 * W, "R10 bound", word_trans, 2 * W);
        total_tr += tr;
        words++;
        lvl_m = spc_e;
    endtask

    initial begin
        rst_n = 1'b0; in_data = '0; in_req = 1'b0;
        force_en = 1'b0; force_val = '0;
        lvl_m = {W{2'b10}};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk(tx_lines == {W{2'b10}}, "R1 lines at spacer", tx_lines, {W{2'b10}});
        chk(!rx_ack && !out_valid, "R1 ack and strobe low", {rx_ack, out_valid}, 0);
        chk(in_rdy, "R1 ready", in_rdy, 1);
        chk(word_trans == '0, "R1 transition report", word_trans, 0);
        // R9: one illegal line, others low
        force_val = '0;
        force_val[1:0] = 2'b11;
        force_en = 1'b1;
        @(negedge clk);
        chk(line_err, "R9 error raised", line_err, 1);
        chk(!out_valid && !rx_ack, "R9 word not accepted", {out_valid, rx_ack}, 0);
        @(negedge clk);
        chk(!out_valid && !rx_ack, "R9 still not accepted", {out_valid, rx_ack}, 0);
        force_en = 1'b0;
        @(negedge clk);
        chk(!line_err, "R9 error cleared", line_err, 0);
        // every ordered pair of words
        for (int a = 0; a < (1 << W); a++) begin
            for (int b = 0; b < (1 << W); b++) begin
                send(W'(a));
                send(W'(b));
            end
        end
        chk(total_tr < words * 2 * W, "R10 saving against full spacer return",
            total_tr, words * 2 * W);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule